// File: doc/BRIEF.md
# Command-Driven Parallel NOR Flash Model

This block is a synthesizable stand-in for a parallel NOR flash device. It sits on a simple synchronous memory bus with chip-select, write-enable, a byte address and separate write and read data. Bus writes are not stored directly. Instead, the low byte of each write is taken as a command, and the commands are interpreted by a multi-cycle state machine. A single address space returns one of three things, chosen by the last command: array contents, the status byte, or a table of device geometry and identity values. The data width can be 8 or 16 bits, and the array is split into equal sectors.

Programming goes through a counted write buffer. Erasing a sector is a sweep that writes all ones, one word per clock. After reset the array is filled from a fixed pattern, also one word per clock. A testbench can therefore predict every word without loading a file.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset the block spends one clock per word filling the array, during which reads return 0x0000 and writes are ignored; word i then holds {i[7:0]^0x5A, i[7:0]} (16-bit) and a new reset refills it.
- R2: A read (cs=1, we=0) places its result on rdata after the next rising edge; rdata is 0 in reset and holds its value on every cycle without a read.
- R3: In array or status mode, the write-data low byte selects: 0x20 erase setup, 0x50 clear status, 0x60 lock setup, 0x70 status mode, 0x98 query mode, 0xE8 buffer program; 0xFF, 0x00 and every other value leave the block in array mode.
- R4: In status mode, erase setup, erase sweep, lock setup and all buffer-program steps, each read returns the status byte zero-extended; bit 7 is the ready flag and bits 6:0 read 0.
- R5: Command 0x50 sets the whole status byte to 0x00 and returns to array mode.
- R6: In query mode a read at byte address A returns table entry A>>1 (16-bit) or A (8-bit). The entries are: 0x51,0x52,0x59 at 0x10..0x12; 0x01,0x00 at 0x13..0x14; log2 of the device byte size at 0x27; 0x01 at 0x2C; sector count minus one at 0x2D..0x2E; sector bytes/256 at 0x2F..0x30; 0x50,0x52,0x49 at 0x31..0x33. Every index of 0x52 or more reads 0.
- R7: In query mode a write of 0xFF returns to array mode; any other write keeps query mode.
- R8: 0x20 followed by 0xD0 erases the sector holding the address of the 0xD0 write to all ones, one word per clock. Status bit 7 is low during the sweep and set at its end, and the block then stays in status mode.
- R9: After 0x20, a second write other than 0xD0 returns to array mode without erasing.
- R10: Bus writes during an erase sweep have no effect on the array, status or mode.
- R11: Buffer program: 0xE8 sets ready, the next write gives count N, the following N+1 writes store their data at their own addresses and set ready, and a final 0xD0 sets ready and returns to array mode.
- R12: After 0x60, a write of 0xD0 or 0x01 sets ready and returns to array mode; any other value returns to array mode with status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select; one bus access per cycle while high |
| we | input | 1 | 1 = write (command or data), 0 = read |
| addr | input | ADDR_W (10) | Byte address |
| wdata | input | DATA_W (16) | Write data; low byte is the command |
| rdata | output | DATA_W (16) | Registered read result |

## Verification
The bench targets the count boundary of buffer programming. A count of zero must take exactly one data word; a design off by one would either store the confirm byte as data or treat a data word as the confirm. Erase is checked at both edges of its sector and at the words just outside it, which catches a wrong sector mask or a sweep that ends early. Other checks look for writes that disturb a running sweep, an abort byte that erases anyway, and a lock value other than 0x01 or 0xD0 that still sets ready. Query reads cover the address scaling and an index just past the table; a missing shift or a wrong limit returns wrong bytes or nonzero data there.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

  typedef enum logic [3:0] {
    ST_FILL,
    ST_ARRAY,
    ST_STATUS,
    ST_ERASE_SETUP,
    ST_ERASE_RUN,
    ST_LOCK_SETUP,
    ST_QUERY,
    ST_BUF_COUNT,
    ST_BUF_DATA,
    ST_BUF_CONFIRM
  } fsm_state_t;

  typedef enum logic [1:0] {
    SRC_ARRAY,
    SRC_STATUS,
    SRC_QUERY
  } rd_src_t;

  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CLEAR    = 8'h50;
  localparam logic [7:0] CMD_LOCK     = 8'h60;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_BUFFER   = 8'hE8;
  localparam logic [7:0] CMD_ARRAY    = 8'hFF;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_LOCK_ALT = 8'h01;

  localparam int READY_BIT = 7;
  localparam int QUERY_LEN = 'h52;

  // Reset-time contents: low byte is the word index, high byte its XOR with 0x5A.
  function automatic logic [15:0] fill_word(input logic [7:0] idx);
    return {idx ^ 8'h5A, idx};
  endfunction

endpackage

// File: rtl/nor_flash_array.sv
module nor_flash_array #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/nor_flash_query.sv
module nor_flash_query #(
  parameter int IDX_W        = 10,
  parameter int DEV_LOG2     = 10,
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_BYTES = 256
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       value
);
  import nor_flash_pkg::*;

  localparam logic [15:0] LAST_SECTOR = 16'(NUM_SECTORS - 1);
  localparam logic [23:0] SEC_BYTES   = 24'(SECTOR_BYTES);

  logic [31:0] ix;
  assign ix = 32'(idx);

  always_comb begin
    value = 8'h00;
    if (ix < 32'(QUERY_LEN)) begin
      case (ix)
        32'h10: value = 8'h51;
        32'h11: value = 8'h52;
        32'h12: value = 8'h59;
        32'h13: value = 8'h01;
        32'h14: value = 8'h00;
        32'h15: value = 8'h31;
        32'h27: value = 8'(DEV_LOG2);
        32'h2C: value = 8'h01;
        32'h2D: value = LAST_SECTOR[7:0];
        32'h2E: value = LAST_SECTOR[15:8];
        32'h2F: value = SEC_BYTES[15:8];
        32'h30: value = SEC_BYTES[23:16];
        32'h31: value = 8'h50;
        32'h32: value = 8'h52;
        32'h33: value = 8'h49;
        32'h34: value = 8'h31;
        32'h35: value = 8'h31;
        default: value = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl #(
  parameter int DATA_W       = 16,
  parameter int NUM_WORDS    = 512,
  parameter int SECTOR_WORDS = 128,
  localparam int WAW         = $clog2(NUM_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs,
  input  logic                    we,
  input  logic [WAW-1:0]          waddr,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    mem_we,
  output logic [WAW-1:0]          mem_waddr,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic [7:0]              status,
  output nor_flash_pkg::rd_src_t  rd_src,
  output logic                    busy,
  output logic                    filling,
  output logic                    cmd_idle
);
  import nor_flash_pkg::*;

  localparam logic [WAW-1:0] SEC_MASK  = WAW'(SECTOR_WORDS - 1);
  localparam logic [WAW-1:0] LAST_WORD = WAW'(NUM_WORDS - 1);

  fsm_state_t     st_q, st_d;
  logic [7:0]     status_q, status_d;
  logic [7:0]     cnt_q, cnt_d;
  logic [WAW-1:0] sweep_q, sweep_d;
  logic [WAW-1:0] base_q, base_d;
  logic [15:0]    fill16;
  logic           wr;
  logic [7:0]     cmd;

  assign wr     = cs & we;
  assign cmd    = wdata[7:0];
  assign fill16 = fill_word(8'(sweep_q));

  always_comb begin
    st_d      = st_q;
    status_d  = status_q;
    cnt_d     = cnt_q;
    sweep_d   = sweep_q;
    base_d    = base_q;
    mem_we    = 1'b0;
    mem_waddr = waddr;
    mem_wdata = wdata;
    case (st_q)
      ST_FILL: begin
        mem_we    = 1'b1;
        mem_waddr = sweep_q;
        mem_wdata = fill16[DATA_W-1:0];
        if (sweep_q == LAST_WORD) begin
          sweep_d = '0;
          st_d    = ST_ARRAY;
        end else begin
          sweep_d = sweep_q + 1'b1;
        end
      end
      ST_ARRAY, ST_STATUS: begin
        if (wr) begin
          case (cmd)
            CMD_ERASE:  st_d = ST_ERASE_SETUP;
            CMD_CLEAR: begin
              status_d = 8'h00;
              st_d     = ST_ARRAY;
            end
            CMD_LOCK:   st_d = ST_LOCK_SETUP;
            CMD_STATUS: st_d = ST_STATUS;
            CMD_QUERY:  st_d = ST_QUERY;
            CMD_BUFFER: begin
              status_d[READY_BIT] = 1'b1;
              st_d = ST_BUF_COUNT;
            end
            default:    st_d = ST_ARRAY;
          endcase
        end
      end
      ST_ERASE_SETUP: begin
        if (wr) begin
          if (cmd == CMD_CONFIRM) begin
            status_d[READY_BIT] = 1'b0;
            base_d  = waddr & ~SEC_MASK;
            sweep_d = '0;
            st_d    = ST_ERASE_RUN;
          end else begin
            st_d = ST_ARRAY;
          end
        end
      end
      ST_ERASE_RUN: begin
        mem_we    = 1'b1;
        mem_waddr = base_q | sweep_q;
        mem_wdata = '1;
        if (sweep_q == SEC_MASK) begin
          sweep_d = '0;
          status_d[READY_BIT] = 1'b1;
          st_d    = ST_STATUS;
        end else begin
          sweep_d = sweep_q + 1'b1;
        end
      end
      ST_LOCK_SETUP: begin
        if (wr) begin
          if (cmd == CMD_CONFIRM || cmd == CMD_LOCK_ALT) status_d[READY_BIT] = 1'b1;
          st_d = ST_ARRAY;
        end
      end
      ST_QUERY: begin
        if (wr && cmd == CMD_ARRAY) st_d = ST_ARRAY;
      end
      ST_BUF_COUNT: begin
        if (wr) begin
          cnt_d = cmd;
          st_d  = ST_BUF_DATA;
        end
      end
      ST_BUF_DATA: begin
        if (wr) begin
          mem_we = 1'b1;
          status_d[READY_BIT] = 1'b1;
          if (cnt_q == 8'd0) st_d = ST_BUF_CONFIRM;
          else               cnt_d = cnt_q - 8'd1;
        end
      end
      ST_BUF_CONFIRM: begin
        if (wr) begin
          if (cmd == CMD_CONFIRM) status_d[READY_BIT] = 1'b1;
          st_d = ST_ARRAY;
        end
      end
      default: st_d = ST_ARRAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_FILL;
      status_q <= 8'h00;
      cnt_q    <= 8'h00;
      sweep_q  <= '0;
      base_q   <= '0;
    end else begin
      st_q     <= st_d;
      status_q <= status_d;
      cnt_q    <= cnt_d;
      sweep_q  <= sweep_d;
      base_q   <= base_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_ARRAY: rd_src = SRC_ARRAY;
      ST_QUERY: rd_src = SRC_QUERY;
      default:  rd_src = SRC_STATUS;
    endcase
  end

  assign status   = status_q;
  assign busy     = (st_q == ST_ERASE_RUN);
  assign filling  = (st_q == ST_FILL);
  assign cmd_idle = (st_q == ST_ARRAY) || (st_q == ST_STATUS);

endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash #(
  parameter int DATA_W       = 16,
  parameter int SECTOR_WORDS = 128,
  parameter int NUM_SECTORS  = 4,
  localparam int BYTES       = DATA_W / 8,
  localparam int SHIFT       = $clog2(BYTES),
  localparam int NUM_WORDS   = SECTOR_WORDS * NUM_SECTORS,
  localparam int TOTAL_BYTES = NUM_WORDS * BYTES,
  localparam int ADDR_W      = $clog2(TOTAL_BYTES),
  localparam int WAW         = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import nor_flash_pkg::*;

  localparam int SECTOR_BYTES = SECTOR_WORDS * BYTES;

  logic [ADDR_W-1:0] unit_idx;
  logic [WAW-1:0]    word_addr;
  logic              re;
  logic              mem_we;
  logic [WAW-1:0]    mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] ram_q;
  logic [7:0]        status;
  logic [7:0]        query_byte;
  rd_src_t           rd_src;
  rd_src_t           sel_q;
  logic [7:0]        aux_q;
  logic              busy;
  logic              filling;
  logic              cmd_idle;

  assign unit_idx  = addr >> SHIFT;
  assign word_addr = unit_idx[WAW-1:0];
  assign re        = cs & ~we;

  nor_flash_ctrl #(
    .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .SECTOR_WORDS(SECTOR_WORDS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cs(cs), .we(we),
    .waddr(word_addr), .wdata(wdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .status(status), .rd_src(rd_src),
    .busy(busy), .filling(filling), .cmd_idle(cmd_idle)
  );

  nor_flash_array #(.DATA_W(DATA_W), .DEPTH(NUM_WORDS)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(re), .raddr(word_addr), .rdata(ram_q)
  );

  nor_flash_query #(
    .IDX_W(ADDR_W), .DEV_LOG2(ADDR_W),
    .NUM_SECTORS(NUM_SECTORS), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_query (
    .idx(unit_idx), .value(query_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SRC_STATUS;
      aux_q <= 8'h00;
    end else if (re) begin
      sel_q <= rd_src;
      aux_q <= (rd_src == SRC_QUERY) ? query_byte : status;
    end
  end

  assign rdata = (sel_q == SRC_ARRAY) ? ram_q : DATA_W'(aux_q);

endmodule

// File: rtl/nor_flash_checker.sv
module nor_flash_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              we,
  input logic [7:0]        cmd,
  input logic [DATA_W-1:0] rdata,
  input logic [7:0]        status,
  input logic              busy,
  input logic              filling,
  input logic              cmd_idle
);

  assert_hold_between_reads_R2: assert property (@(posedge clk) disable iff (rst)
    !(cs && !we) |=> $stable(rdata));

  assert_fill_reads_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && filling) |=> (rdata == '0));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && busy) |=> !rdata[7]);

  assert_sweep_end_ready_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> status[7]);

  assert_sweep_not_cut_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && cs && we) |=> (busy || status[7]));

  assert_clear_zeroes_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_idle && cs && we && cmd == 8'h50) |=> (status == 8'h00));

endmodule

bind nor_cmd_flash nor_flash_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .rst(rst), .cs(cs), .we(we), .cmd(wdata[7:0]),
  .rdata(rdata), .status(status), .busy(busy),
  .filling(filling), .cmd_idle(cmd_idle)
);

// File: tb/nor_cmd_flash_bench.sv
module nor_cmd_flash_bench;

  localparam int NV = 47;

  logic        clk = 1'b0;
  logic        rst;
  logic        cs;
  logic        we;
  logic [9:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  nor_cmd_flash u_nor_cmd_flash (
    .clk(clk), .rst(rst), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #4 clk = ~clk;

  // {is_write, req, byte address, data or expected value}
  localparam logic [30:0] VECS [NV] = '{
    {1'b0, 4'd1,  10'h000, 16'h5A00},  // R1 word 0
    {1'b0, 4'd1,  10'h0A2, 16'h0B51},  // R1 word 0x51
    {1'b1, 4'd0,  10'h000, 16'h0070},
    {1'b0, 4'd4,  10'h000, 16'h0000},  // R4 status after reset
    {1'b1, 4'd0,  10'h000, 16'h0098},
    {1'b0, 4'd6,  10'h020, 16'h0051},  // R6
    {1'b0, 4'd6,  10'h022, 16'h0052},
    {1'b0, 4'd6,  10'h024, 16'h0059},
    {1'b0, 4'd6,  10'h026, 16'h0001},
    {1'b0, 4'd6,  10'h04E, 16'h000A},
    {1'b0, 4'd6,  10'h058, 16'h0001},
    {1'b0, 4'd6,  10'h05A, 16'h0003},
    {1'b0, 4'd6,  10'h05E, 16'h0001},
    {1'b0, 4'd6,  10'h062, 16'h0050},
    {1'b0, 4'd6,  10'h066, 16'h0049},
    {1'b0, 4'd6,  10'h0A4, 16'h0000},  // R6 index 0x52
    {1'b1, 4'd0,  10'h000, 16'h0012},
    {1'b0, 4'd7,  10'h020, 16'h0051},  // R7 still query
    {1'b1, 4'd0,  10'h000, 16'h00FF},
    {1'b0, 4'd7,  10'h000, 16'h5A00},  // R7 back to array
    {1'b1, 4'd0,  10'h100, 16'h00E8},
    {1'b0, 4'd11, 10'h100, 16'h0080},  // R11 ready after 0xE8
    {1'b1, 4'd0,  10'h100, 16'h0001},
    {1'b1, 4'd0,  10'h100, 16'hBEEF},
    {1'b1, 4'd0,  10'h102, 16'h1234},
    {1'b1, 4'd0,  10'h100, 16'h00D0},
    {1'b0, 4'd11, 10'h100, 16'hBEEF},
    {1'b0, 4'd11, 10'h102, 16'h1234},
    {1'b0, 4'd11, 10'h104, 16'hD882},
    {1'b1, 4'd0,  10'h000, 16'h0050},
    {1'b1, 4'd0,  10'h000, 16'h0070},
    {1'b0, 4'd5,  10'h000, 16'h0000},  // R5
    {1'b1, 4'd0,  10'h000, 16'h0060},
    {1'b0, 4'd4,  10'h000, 16'h0000},  // R4 lock setup shows status
    {1'b1, 4'd0,  10'h000, 16'h0001},
    {1'b0, 4'd12, 10'h000, 16'h5A00},  // R12 array after lock
    {1'b1, 4'd0,  10'h000, 16'h0070},
    {1'b0, 4'd12, 10'h000, 16'h0080},  // R12 ready
    {1'b1, 4'd0,  10'h000, 16'h0050},
    {1'b1, 4'd0,  10'h000, 16'h00AB},
    {1'b0, 4'd3,  10'h002, 16'h5B01},  // R3 unknown -> array
    {1'b1, 4'd0,  10'h100, 16'h0020},
    {1'b0, 4'd4,  10'h100, 16'h0000},  // R4 erase setup shows status
    {1'b1, 4'd0,  10'h100, 16'h00FF},
    {1'b0, 4'd9,  10'h100, 16'hBEEF},  // R9 aborted, no erase
    {1'b1, 4'd0,  10'h000, 16'h0000},
    {1'b0, 4'd3,  10'h0A2, 16'h0B51}   // R3 0x00 keeps array
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
    check(tag, rdata, e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 reset value", rdata, 16'h0000);
    rst = 1'b0;
    rd(10'h000, 16'h0000, "R1 read during fill");
    repeat (530) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][30]) wr(VECS[i][25:16], VECS[i][15:0]);
      else rd(VECS[i][25:16], VECS[i][15:0], $sformatf("R%0d vector %0d", VECS[i][29:26], i));
    end

    // R8 / R10: erase sector 1 with writes arriving during the sweep
    wr(10'h100, 16'h0020);
    wr(10'h100, 16'h00D0);
    rd(10'h100, 16'h0000, "R8 busy status");
    wr(10'h000, 16'h0050);
    wr(10'h000, 16'h00FF);
    wr(10'h040, 16'h1111);
    repeat (150) @(negedge clk);
    rd(10'h100, 16'h0080, "R10 status mode kept, R8 ready");
    wr(10'h000, 16'h00FF);
    rd(10'h100, 16'hFFFF, "R8 first word of sector");
    rd(10'h1FE, 16'hFFFF, "R8 last word of sector");
    rd(10'h0FE, 16'h257F, "R8 word below sector");
    rd(10'h200, 16'h5A00, "R8 word above sector");
    rd(10'h040, 16'h7A20, "R10 array not written");

    // R11 count of zero: exactly one data word
    wr(10'h004, 16'h00E8);
    wr(10'h004, 16'h0000);
    wr(10'h004, 16'hCAFE);
    rd(10'h004, 16'h0080, "R11 confirm step status");
    wr(10'h006, 16'h00D0);
    rd(10'h004, 16'hCAFE, "R11 single word stored");
    rd(10'h006, 16'h5903, "R11 confirm not stored");

    // R12 other value after lock setup
    wr(10'h000, 16'h0050);
    wr(10'h000, 16'h0060);
    wr(10'h000, 16'h0033);
    rd(10'h002, 16'h5B01, "R12 array after other value");
    wr(10'h000, 16'h0070);
    rd(10'h000, 16'h0000, "R12 ready not set");

    // R9 erase setup followed by a non-confirm value
    wr(10'h000, 16'h00FF);
    wr(10'h000, 16'h0020);
    wr(10'h000, 16'h0044);
    rd(10'h000, 16'h5A00, "R9 sector 0 intact");

    // R1 reset in query mode refills the array
    wr(10'h000, 16'h0098);
    do_reset();
    rd(10'h000, 16'h5A00, "R1 array mode after reset");
    rd(10'h100, 16'hDA80, "R1 erased word refilled");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule